// File: doc/BRIEF.md
# DRAM Auto-Access Address Sequencer

This block turns a single falling row-strobe request into a complete row/column access to a multiplexed-address DRAM array. While the request is high, the parallel row address, column address and bank select pass straight through an open input latch. When the request is seen low at a clock edge, the latch closes. The decoded active-low row strobe for the chosen bank then goes low with the row half on the shared address pins. After a row hold interval the pins switch to the column half, and after a column setup interval the column strobe goes low. Raising the request ends the access: both strobes return high and the pins go back to the row half.

All delays are counted in system clock cycles. Two automatic modes differ only in the row hold length, a longer one and a shorter one. A third mode, for external access, hands the row strobe timing, the column strobe and the row/column pin selection straight to external inputs, with no counted delays. The write enable is a plain buffer, separate from the sequencer. Every other mode code keeps all strobes inactive.

Top module: `dram_access_seq`

## Requirements
- R1: Mode codes on `mode_sel` are 3'b101 (automatic, slow hold), 3'b110 (automatic, fast hold) and 3'b100 (external access). Any other code keeps every `ras_n` bit and `cas_n` high and leaves the pins on the row half, even when the request stays low.
- R2: In an automatic mode, a clock edge that samples `rowreq_n` low while no access is running starts one. From that edge on, `ras_n` is all ones except for a single 0 at bit index `bank_sel`, and `mem_addr` carries the latched row address.
- R3: Counted from the starting edge, the row address stays on `mem_addr` for exactly SLOW_HOLD cycles (default 2) in mode 3'b101 or FAST_HOLD cycles (default 1) in mode 3'b110. At the next edge `mem_addr` switches to the latched column address.
- R4: `cas_n` goes low exactly COL_SETUP cycles (default 1) after the column switch. It stays low with the column address held until the access is released.
- R5: While the latch is open (no access running and `rowreq_n` high), `mem_addr` follows `row_addr_in` combinationally. Otherwise the block uses the row, column and bank values sampled at the last clock edge with `rowreq_n` high. Input changes during an access have no effect on the outputs.
- R6: A clock edge that samples `rowreq_n` high during an automatic access ends it, even in the hold or setup interval. Afterwards `ras_n` is all ones, `cas_n` is high and `mem_addr` shows the row input.
- R7: In mode 3'b100, `ras_n` shows the decoded latched bank (single 0 bit) whenever `rowreq_n` is low, combinationally, and all ones otherwise. `cas_n` equals `ext_cas_n`. `mem_addr` shows the column half when `ext_col_sel` is 1 and the row half when it is 0.
- R8: `we_n` always equals `we_req_n`, in every mode and state.
- R9: Mode changes after an access has started do not alter its timing or its outputs.
- R10: During and right after reset, `ras_n` is all ones and `cas_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that counts the delays |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Operating mode code |
| rowreq_n | input | 1 | Row strobe request, active low |
| bank_sel | input | BANK_W (2) | Bank whose row strobe is driven |
| row_addr_in | input | ADDR_W (8) | Row half of the parallel address |
| col_addr_in | input | ADDR_W (8) | Column half of the parallel address |
| we_req_n | input | 1 | System write enable, active low |
| ext_col_sel | input | 1 | External-mode pin select, 1 picks the column half |
| ext_cas_n | input | 1 | External-mode column strobe |
| mem_addr | output | ADDR_W (8) | Multiplexed DRAM address |
| ras_n | output | NUM_BANKS (4) | Decoded active-low row strobes |
| cas_n | output | 1 | Active-low column strobe |
| we_n | output | 1 | Buffered write enable |

## Verification
If the hold or setup counter is off, the column address or the column strobe appears one cycle early or late relative to the row strobe edge. The bench catches this on the first access in the affected mode, because it checks every cycle after the starting edge. A latch that fails to close shows up in the same cycle the bench scrambles the inputs, as a changed `mem_addr` or a different row strobe bit. A sequencer state that fails to clear on release leaves a row strobe low, or the column half on the pins, at the first sample after the releasing edge.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_HOLD   = 2'd1,
      ST_SETUP  = 2'd2,
      ST_ACTIVE = 2'd3
   } seq_state_e;

   localparam logic [2:0] MODE_EXT  = 3'b100;
   localparam logic [2:0] MODE_SLOW = 3'b101;
   localparam logic [2:0] MODE_FAST = 3'b110;

   function automatic logic is_auto_mode(input logic [2:0] m);
      return (m == MODE_SLOW) || (m == MODE_FAST);
   endfunction

endpackage

// File: rtl/dram_addr_latch.sv
module dram_addr_latch #(
   parameter int ADDR_W = 8,
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADDR_W-1:0] row_in,
   input  logic [ADDR_W-1:0] col_in,
   input  logic [BANK_W-1:0] bank_in,
   output logic [ADDR_W-1:0] row_q,
   output logic [ADDR_W-1:0] col_q,
   output logic [BANK_W-1:0] bank_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         col_q  <= '0;
         bank_q <= '0;
      end else if (capture) begin
         row_q  <= row_in;
         col_q  <= col_in;
         bank_q <= bank_in;
      end
   end

   // R5: a closed latch holds its contents
   p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> ($stable(row_q) && $stable(col_q) && $stable(bank_q)));

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
   import dram_seq_pkg::*;
#(
   parameter int FAST_HOLD = 1,
   parameter int SLOW_HOLD = 2,
   parameter int COL_SETUP = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_sel,
   input  logic       rowreq_n,
   output seq_state_e state
);

   localparam int MAX_HS = (SLOW_HOLD > COL_SETUP) ? SLOW_HOLD : COL_SETUP;
   localparam int MAX_D  = (FAST_HOLD > MAX_HS) ? FAST_HOLD : MAX_HS;
   localparam int CNT_W  = $clog2(MAX_D + 1);

   localparam logic [CNT_W-1:0] FAST_LEN  = CNT_W'(FAST_HOLD);
   localparam logic [CNT_W-1:0] SLOW_LEN  = CNT_W'(SLOW_HOLD);
   localparam logic [CNT_W-1:0] SETUP_LEN = CNT_W'(COL_SETUP);

   generate
      if (FAST_HOLD < 1) begin : g_bad_fast
         $error("FAST_HOLD must be at least one cycle");
      end
      if (SLOW_HOLD < FAST_HOLD) begin : g_bad_slow
         $error("SLOW_HOLD must not be shorter than FAST_HOLD");
      end
      if (COL_SETUP < 1) begin : g_bad_setup
         $error("COL_SETUP must be at least one cycle");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] hold_len;
   logic [CNT_W-1:0] hold_len_q;

   assign hold_len = (mode_sel == MODE_SLOW) ? SLOW_LEN : FAST_LEN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt_q      <= '0;
         hold_len_q <= FAST_LEN;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (is_auto_mode(mode_sel) && !rowreq_n) begin
                  state      <= ST_HOLD;
                  cnt_q      <= hold_len - 1'b1;
                  hold_len_q <= hold_len;
               end
            end
            ST_HOLD: begin
               if (rowreq_n) begin
                  state <= ST_IDLE;
               end else if (cnt_q == '0) begin
                  state <= ST_SETUP;
                  cnt_q <= SETUP_LEN - 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_SETUP: begin
               if (rowreq_n) begin
                  state <= ST_IDLE;
               end else if (cnt_q == '0) begin
                  state <= ST_ACTIVE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (rowreq_n) state <= ST_IDLE;
            end
         endcase
      end
   end

   // Independent run-length counters used only by the checks below
   logic [CNT_W:0] hold_run;
   logic [CNT_W:0] setup_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_run  <= '0;
         setup_run <= '0;
      end else begin
         hold_run  <= (state == ST_HOLD)  ? hold_run + 1'b1  : '0;
         setup_run <= (state == ST_SETUP) ? setup_run + 1'b1 : '0;
      end
   end

   // R3: row hold lasts the length chosen at the start of the access
   p_hold_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SETUP && $past(state) == ST_HOLD) |-> (hold_run == {1'b0, hold_len_q}));

   // R4: column setup lasts COL_SETUP cycles
   p_setup_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE && $past(state) == ST_SETUP) |-> (setup_run == {1'b0, SETUP_LEN}));

   // R6: a high request during an access returns to idle
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && rowreq_n) |=> (state == ST_IDLE));

   // R1: non-automatic modes never start an access
   p_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !is_auto_mode(mode_sel)) |=> (state == ST_IDLE));

endmodule

// File: rtl/dram_strobe_out.sv
module dram_strobe_out
   import dram_seq_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
) (
   input  seq_state_e           state,
   input  logic                 ext_mode,
   input  logic                 rowreq_n,
   input  logic                 ext_col_sel,
   input  logic                 ext_cas_n,
   input  logic [ADDR_W-1:0]    row_in,
   input  logic [ADDR_W-1:0]    col_in,
   input  logic [ADDR_W-1:0]    row_q,
   input  logic [ADDR_W-1:0]    col_q,
   input  logic [BANK_W-1:0]    bank_q,
   output logic                 latch_open,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [NUM_BANKS-1:0] ras_n,
   output logic                 cas_n
);

   logic                 busy;
   logic                 col_pick;
   logic                 ras_on;
   logic [NUM_BANKS-1:0] bank_hit;

   genvar g;
   generate
      for (g = 0; g < NUM_BANKS; g++) begin : g_bank
         assign bank_hit[g] = (bank_q == BANK_W'(g));
      end
   endgenerate

   assign busy       = (state != ST_IDLE);
   assign latch_open = !busy && rowreq_n;

   always_comb begin
      if (busy) begin
         ras_on   = 1'b1;
         col_pick = (state == ST_SETUP) || (state == ST_ACTIVE);
         cas_n    = (state != ST_ACTIVE);
      end else if (ext_mode) begin
         ras_on   = !rowreq_n;
         col_pick = ext_col_sel;
         cas_n    = ext_cas_n;
      end else begin
         ras_on   = 1'b0;
         col_pick = 1'b0;
         cas_n    = 1'b1;
      end
   end

   always_comb begin
      if (col_pick) mem_addr = latch_open ? col_in : col_q;
      else          mem_addr = latch_open ? row_in : row_q;
   end

   assign ras_n = ras_on ? ~bank_hit : '1;

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
   import dram_seq_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int NUM_BANKS = 4,
   parameter int FAST_HOLD = 1,
   parameter int SLOW_HOLD = 2,
   parameter int COL_SETUP = 1,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           mode_sel,
   input  logic                 rowreq_n,
   input  logic [BANK_W-1:0]    bank_sel,
   input  logic [ADDR_W-1:0]    row_addr_in,
   input  logic [ADDR_W-1:0]    col_addr_in,
   input  logic                 we_req_n,
   input  logic                 ext_col_sel,
   input  logic                 ext_cas_n,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [NUM_BANKS-1:0] ras_n,
   output logic                 cas_n,
   output logic                 we_n
);

   generate
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be positive");
      end
   endgenerate

   seq_state_e        state;
   logic              latch_open;
   logic [ADDR_W-1:0] row_q;
   logic [ADDR_W-1:0] col_q;
   logic [BANK_W-1:0] bank_q;

   dram_seq_fsm #(
      .FAST_HOLD (FAST_HOLD),
      .SLOW_HOLD (SLOW_HOLD),
      .COL_SETUP (COL_SETUP)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_sel (mode_sel),
      .rowreq_n (rowreq_n),
      .state    (state)
   );

   dram_addr_latch #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (rowreq_n),
      .row_in  (row_addr_in),
      .col_in  (col_addr_in),
      .bank_in (bank_sel),
      .row_q   (row_q),
      .col_q   (col_q),
      .bank_q  (bank_q)
   );

   dram_strobe_out #(
      .ADDR_W    (ADDR_W),
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_out (
      .state       (state),
      .ext_mode    (mode_sel == MODE_EXT),
      .rowreq_n    (rowreq_n),
      .ext_col_sel (ext_col_sel),
      .ext_cas_n   (ext_cas_n),
      .row_in      (row_addr_in),
      .col_in      (col_addr_in),
      .row_q       (row_q),
      .col_q       (col_q),
      .bank_q      (bank_q),
      .latch_open  (latch_open),
      .mem_addr    (mem_addr),
      .ras_n       (ras_n),
      .cas_n       (cas_n)
   );

   // R8: write enable is a plain buffer
   assign we_n = we_req_n;

   // R2: at most one row strobe active
   p_ras_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ras_n));

   // R4: automatic column strobe only under an active row strobe
   p_cas_under_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && !cas_n) |-> ($countones(~ras_n) == 1));

   // R5: the address pins cannot move while an access holds the column strobe
   p_col_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE && $past(state) == ST_ACTIVE) |-> $stable(mem_addr));

endmodule

// File: tb/dram_access_seq_bench.sv
module dram_access_seq_bench;

   localparam int ADDR_W = 8;
   localparam int NB     = 4;
   localparam int FAST   = 1;
   localparam int SLOW   = 2;
   localparam int SETUP  = 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        mode_sel = 3'b000;
   logic              rowreq_n = 1'b1;
   logic [1:0]        bank_sel = '0;
   logic [ADDR_W-1:0] row_addr_in = '0;
   logic [ADDR_W-1:0] col_addr_in = '0;
   logic              we_req_n = 1'b1;
   logic              ext_col_sel = 1'b0;
   logic              ext_cas_n = 1'b1;
   logic [ADDR_W-1:0] mem_addr;
   logic [NB-1:0]     ras_n;
   logic              cas_n;
   logic              we_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dram_access_seq u_dram_access_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_sel    (mode_sel),
      .rowreq_n    (rowreq_n),
      .bank_sel    (bank_sel),
      .row_addr_in (row_addr_in),
      .col_addr_in (col_addr_in),
      .we_req_n    (we_req_n),
      .ext_col_sel (ext_col_sel),
      .ext_cas_n   (ext_cas_n),
      .mem_addr    (mem_addr),
      .ras_n       (ras_n),
      .cas_n       (cas_n),
      .we_n        (we_n)
   );

   function automatic logic [NB-1:0] exp_ras(input logic [1:0] b);
      return ~(NB'(1) << b);
   endfunction

   function automatic int hold_of(input logic [2:0] m);
      return (m == 3'b101) ? SLOW : FAST;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // advance one edge, then settle away from it
   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic auto_access(input logic [2:0] m, input logic [1:0] b,
                              input logic [ADDR_W-1:0] r, input logic [ADDR_W-1:0] c,
                              input int len, input bit scramble);
      int h;
      h = hold_of(m);
      mode_sel = m; bank_sel = b; row_addr_in = r; col_addr_in = c; rowreq_n = 1'b1;
      tick();
      #1;
      chk(mem_addr == r, "R5 open follows row", 32'(mem_addr), 32'(r));
      chk(ras_n == '1, "R6 idle strobes", 32'(ras_n), 32'hF);
      rowreq_n = 1'b0;
      #1;
      chk(mem_addr == r, "R5 closed latch row", 32'(mem_addr), 32'(r));
      for (int t = 0; t <= len; t++) begin
         tick();
         if (scramble) begin
            row_addr_in = ADDR_W'($urandom); col_addr_in = ADDR_W'($urandom);
            bank_sel = 2'($urandom); mode_sel = 3'($urandom);
         end
         #1;
         chk(ras_n == exp_ras(b), "R2 row strobe", 32'(ras_n), 32'(exp_ras(b)));
         if (t < h) begin
            chk(mem_addr == r && cas_n, "R3 row hold", 32'({cas_n, mem_addr}), 32'({1'b1, r}));
         end else if (t < h + SETUP) begin
            chk(mem_addr == c && cas_n, "R3 column switch", 32'({cas_n, mem_addr}), 32'({1'b1, c}));
         end else begin
            chk(mem_addr == c && !cas_n, "R4 column strobe", 32'({cas_n, mem_addr}), 32'({1'b0, c}));
         end
      end
      if (scramble) begin
         chk(ras_n == exp_ras(b), "R9 mode change ignored", 32'(ras_n), 32'(exp_ras(b)));
      end
      mode_sel = m;
      rowreq_n = 1'b1;
      tick();
      #1;
      chk(ras_n == '1 && cas_n, "R6 release strobes", 32'({cas_n, ras_n}), 32'h1F);
      chk(mem_addr == row_addr_in, "R6 release row", 32'(mem_addr), 32'(row_addr_in));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd1905));
      #3;
      chk(ras_n == '1 && cas_n, "R10 in reset", 32'({cas_n, ras_n}), 32'h1F);
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk(ras_n == '1 && cas_n, "R10 after reset", 32'({cas_n, ras_n}), 32'h1F);

      // directed: both hold lengths, every bank
      auto_access(3'b101, 2'd0, 8'h3C, 8'hA5, 5, 1'b0);
      auto_access(3'b110, 2'd3, 8'h81, 8'h7E, 5, 1'b0);
      auto_access(3'b101, 2'd2, 8'hFF, 8'h00, 4, 1'b1);
      auto_access(3'b110, 2'd1, 8'h00, 8'hFF, 4, 1'b1);
      // abort inside the hold interval (R6)
      auto_access(3'b101, 2'd1, 8'h55, 8'hAA, 0, 1'b0);
      chk(cas_n, "R6 abort no strobe", 32'(cas_n), 32'h1);

      // other mode codes stay inactive (R1)
      foreach (ext_codes_dummy[i]) begin end
      for (int k = 0; k < 8; k++) begin
         logic [2:0] m;
         m = 3'(k);
         if (m == 3'b100 || m == 3'b101 || m == 3'b110) continue;
         mode_sel = m; row_addr_in = 8'(8'h11 * k); bank_sel = 2'(k); rowreq_n = 1'b1;
         tick();
         rowreq_n = 1'b0;
         tick(); tick();
         #1;
         chk(ras_n == '1 && cas_n, "R1 idle mode strobes", 32'({cas_n, ras_n}), 32'h1F);
         chk(mem_addr == 8'(8'h11 * k), "R1 idle mode row", 32'(mem_addr), 32'(8'h11 * k));
         rowreq_n = 1'b1;
      end

      // external access mode (R7)
      mode_sel = 3'b100; bank_sel = 2'd2; row_addr_in = 8'h1A; col_addr_in = 8'hC7;
      ext_col_sel = 1'b0; ext_cas_n = 1'b1; rowreq_n = 1'b1;
      tick();
      chk(ras_n == '1, "R7 ext idle", 32'(ras_n), 32'hF);
      rowreq_n = 1'b0;
      #1;
      chk(ras_n == exp_ras(2'd2), "R7 ext row strobe", 32'(ras_n), 32'(exp_ras(2'd2)));
      chk(mem_addr == 8'h1A, "R7 ext row half", 32'(mem_addr), 32'h1A);
      tick();
      row_addr_in = 8'h00; col_addr_in = 8'h00; bank_sel = 2'd0;
      ext_col_sel = 1'b1;
      #1;
      chk(mem_addr == 8'hC7, "R7 ext column half", 32'(mem_addr), 32'hC7);
      chk(cas_n, "R7 ext cas high", 32'(cas_n), 32'h1);
      ext_cas_n = 1'b0;
      #1;
      chk(!cas_n, "R7 ext cas follows", 32'(cas_n), 32'h0);
      tick(); tick();
      chk(ras_n == exp_ras(2'd2), "R5 ext latch holds bank", 32'(ras_n), 32'(exp_ras(2'd2)));
      rowreq_n = 1'b1; ext_cas_n = 1'b1; ext_col_sel = 1'b0;
      #1;
      chk(ras_n == '1 && cas_n, "R7 ext release", 32'({cas_n, ras_n}), 32'h1F);
      tick();

      // write enable buffer (R8)
      for (int k = 0; k < 6; k++) begin
         we_req_n = 1'($urandom);
         mode_sel = 3'($urandom);
         #1;
         chk(we_n == we_req_n, "R8 write enable", 32'(we_n), 32'(we_req_n));
         tick();
      end

      // constrained random accesses
      for (int k = 0; k < 40; k++) begin
         logic [2:0] m;
         m = ($urandom % 2) ? 3'b101 : 3'b110;
         auto_access(m, 2'($urandom), ADDR_W'($urandom), ADDR_W'($urandom),
                     int'($urandom % 6), 1'($urandom));
         we_req_n = 1'($urandom);
         #1;
         chk(we_n == we_req_n, "R8 write enable random", 32'(we_n), 32'(we_req_n));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   int ext_codes_dummy[1];

endmodule